// File: doc/BRIEF.md
# Event Data Frame Packer

This block sits between a front-end data buffer and the collection buffer of a data acquisition node. It takes 16-bit data words from a valid/ready stream and wraps them into frames that describe themselves. Every frame opens with a zero start code. Three header words follow: one carries the board identity, one the total frame length in bytes, and one a rolling frame number. The payload comes after the header. Because the numbers are consecutive, a reader that sees a gap in them knows that frames were lost.

The frame length follows a two-bit event-rate band. A quiet source gets short frames, so data does not wait long before it is shipped. A busy source gets long frames, so less of the stream is spent on headers. The band is sampled once, when a frame opens. When the source has no word ready, the packer pads the payload with a fill word instead of stalling. A flush input closes the open frame early, and it does so with padding. A frame opens only when the source presents data, so the packer emits no empty frames while it is idle.

Top module: `evt_framer`

## Requirements
- R1: After reset, out_valid and in_ready are both low, and the first frame emitted carries frame number 1.
- R2: A frame opens only when in_valid is high while no frame is open. The first word of every frame is the start code 16'h0000.
- R3: The second word is the identity word. Bits 15:8 hold bd_addr, bits 7:6 hold bd_kind, bit 5 holds bd_master and bits 4:0 hold bd_rev.
- R4: The third word gives the frame length in bytes. Band 0 gives 64, band 1 gives 128, and bands 2 and 3 give 256. A frame carries exactly length/2 words, with the four header words included. out_last is high on the final word only, and the packer is idle in the cycle after that word is taken.
- R5: The fourth word is the frame number. It rises by one with each frame. After 2^SEQ_W-1 it returns to 1, and it is never 0.
- R6: During the payload, a word offered with in_valid is passed through to out_data in its arrival order. in_ready equals out_ready in that cycle.
- R7: During the payload, a cycle without in_valid emits the fill word 16'hFFFF. That word counts toward the frame length.
- R8: A flush pulse while a frame is open makes that word and every remaining payload word a fill word. in_ready stays low until the frame ends. A flush while no frame is open has no effect.
- R9: A band change while a frame is open does not alter that frame. The next frame uses the band present when it opens.
- R10: While out_ready is low, no input word is taken, out_valid stays high, and a header word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source word available |
| in_data | input | 16 | Source word, never 0 |
| in_ready | output | 1 | Source word taken this cycle |
| bd_addr | input | 8 | Board address |
| bd_kind | input | 2 | Board function type |
| bd_master | input | 1 | Board role, 1 for collector |
| bd_rev | input | 5 | Board revision |
| rate_band | input | 2 | Event-rate band that selects the frame length |
| flush | input | 1 | Close the open frame with padding |
| out_valid | output | 1 | Framed word available |
| out_data | output | 16 | Framed word |
| out_last | output | 1 | Final word of a frame |
| out_ready | input | 1 | Sink takes the framed word |

## Verification
The hardest state to reach is the frame-number wrap. It needs thousands of frames at the default width, so the bench builds the block with a 5-bit counter and runs enough random frames to pass the wrap point more than once. Flush timing is also hard to set up, because its effect depends on the exact payload slot it lands in. The directed test follows the word count at the output and raises flush just before the sixth payload word. It then expects exactly five data words followed by fill. A band change is made between the header and the payload, and the length of that frame and of the next frame are both checked.

// File: rtl/evt_framer_pkg.sv
package evt_framer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } frm_state_e;

  localparam int HDR_WORDS = 4;

  // identity word: address above, then type, role, revision
  function automatic logic [15:0] pack_ident(input logic [7:0] a, input logic [1:0] k,
                                             input logic m, input logic [4:0] r);
    return {a, k, m, r};
  endfunction

  // band to frame length in bytes
  function automatic int band_bytes(input logic [1:0] band, input int lo, input int mid,
                                    input int hi);
    if (band == 2'd0) return lo;
    else if (band == 2'd1) return mid;
    else return hi;
  endfunction

endpackage

// File: rtl/framer_len_sel.sv
module framer_len_sel #(
  parameter int LEN0_BYTES = 64,
  parameter int LEN1_BYTES = 128,
  parameter int LEN2_BYTES = 256,
  parameter int CNT_W      = 8
) (
  input  logic [1:0]       band,
  output logic [CNT_W-1:0] words
);
  import evt_framer_pkg::*;

  logic [CNT_W-1:0] w_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_band
    localparam int BYTES = band_bytes(2'(g), LEN0_BYTES, LEN1_BYTES, LEN2_BYTES);
    assign w_tab[g] = CNT_W'(BYTES / 2);
  end

  assign words = w_tab[band];
endmodule

// File: rtl/framer_seq_ctr.sv
module framer_seq_ctr #(
  parameter int SEQ_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [15:0] seq
);
  localparam logic [SEQ_W-1:0] SEQ_TOP = '1;
  localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);

  logic [SEQ_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= SEQ_ONE;
    else if (adv) cnt_q <= (cnt_q == SEQ_TOP) ? SEQ_ONE : cnt_q + SEQ_ONE;
  end

  if (SEQ_W < 16) begin : g_ext
    assign seq = {{(16 - SEQ_W){1'b0}}, cnt_q};
  end else begin : g_full
    assign seq = cnt_q[15:0];
  end
endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import evt_framer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic             flush,
  input  logic [CNT_W-1:0] words_sel,
  output frm_state_e       state,
  output logic [CNT_W-1:0] widx,
  output logic [CNT_W-1:0] tot_words,
  output logic             start,
  output logic             is_last,
  output logic             frame_done,
  output logic             pad_now
);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_WORDS - 1);

  frm_state_e       state_q;
  logic [CNT_W-1:0] widx_q;
  logic [CNT_W-1:0] tot_q;
  logic             pad_q;

  assign state      = state_q;
  assign widx       = widx_q;
  assign tot_words  = tot_q;
  assign start      = (state_q == ST_IDLE) && in_valid;
  assign is_last    = (state_q == ST_PAY) && (widx_q == tot_q - 1'b1);
  assign frame_done = is_last && out_ready;
  assign pad_now    = (state_q != ST_IDLE) && (pad_q || flush);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      tot_q   <= '0;
      pad_q   <= 1'b0;
    end else begin
      if (start) pad_q <= 1'b0;
      else if (flush && state_q != ST_IDLE) pad_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            state_q <= ST_HDR;
            widx_q  <= '0;
            tot_q   <= words_sel;
          end
        end
        ST_HDR: begin
          if (out_ready) begin
            widx_q <= widx_q + 1'b1;
            if (widx_q == HDR_LAST) state_q <= ST_PAY;
          end
        end
        ST_PAY: begin
          if (out_ready) begin
            if (is_last) begin
              state_q <= ST_IDLE;
              widx_q  <= '0;
            end else begin
              widx_q <= widx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_framer.sv
module evt_framer
  import evt_framer_pkg::*;
#(
  parameter int          LEN0_BYTES = 64,
  parameter int          LEN1_BYTES = 128,
  parameter int          LEN2_BYTES = 256,
  parameter int          SEQ_W      = 16,
  parameter logic [15:0] FILL       = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_data,
  output logic        in_ready,
  input  logic [7:0]  bd_addr,
  input  logic [1:0]  bd_kind,
  input  logic        bd_master,
  input  logic [4:0]  bd_rev,
  input  logic [1:0]  rate_band,
  input  logic        flush,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic        out_last,
  input  logic        out_ready
);
  localparam int MAX_WORDS = LEN2_BYTES / 2;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  frm_state_e       state;
  logic [CNT_W-1:0] widx;
  logic [CNT_W-1:0] tot_words;
  logic [CNT_W-1:0] words_sel;
  logic             start;
  logic             is_last;
  logic             frame_done;
  logic             pad_now;
  logic [15:0]      seq;
  logic [15:0]      id_q;
  logic [15:0]      len_bytes;

  // named events for the checker
  logic in_payload;
  logic sof;
  logic len_word;
  logic seq_word;

  framer_len_sel #(
    .LEN0_BYTES(LEN0_BYTES),
    .LEN1_BYTES(LEN1_BYTES),
    .LEN2_BYTES(LEN2_BYTES),
    .CNT_W     (CNT_W)
  ) u_len (
    .band (rate_band),
    .words(words_sel)
  );

  framer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .flush     (flush),
    .words_sel (words_sel),
    .state     (state),
    .widx      (widx),
    .tot_words (tot_words),
    .start     (start),
    .is_last   (is_last),
    .frame_done(frame_done),
    .pad_now   (pad_now)
  );

  framer_seq_ctr #(.SEQ_W(SEQ_W)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (frame_done),
    .seq  (seq)
  );

  // identity captured at frame open so a frame is self-consistent
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= '0;
    else if (start) id_q <= pack_ident(bd_addr, bd_kind, bd_master, bd_rev);
  end

  assign len_bytes  = {{(15 - CNT_W){1'b0}}, tot_words, 1'b0};
  assign in_payload = (state == ST_PAY);
  assign sof        = (state == ST_HDR) && (widx == '0);
  assign len_word   = (state == ST_HDR) && (widx == CNT_W'(2));
  assign seq_word   = (state == ST_HDR) && (widx == CNT_W'(3));

  assign out_valid  = (state != ST_IDLE);
  assign out_last   = is_last;
  assign in_ready   = in_payload && out_ready && !pad_now;

  always_comb begin
    out_data = '0;
    if (state == ST_HDR) begin
      unique case (widx[1:0])
        2'd0:    out_data = 16'h0000;
        2'd1:    out_data = id_q;
        2'd2:    out_data = len_bytes;
        default: out_data = seq;
      endcase
    end else if (in_payload) begin
      out_data = (pad_now || !in_valid) ? FILL : in_data;
    end
  end
endmodule

// File: rtl/evt_framer_chk.sv
module evt_framer_chk #(
  parameter int LEN0_BYTES = 64,
  parameter int LEN1_BYTES = 128,
  parameter int LEN2_BYTES = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic [15:0] out_data,
  input logic        out_last,
  input logic        out_ready,
  input logic        sof,
  input logic        len_word,
  input logic        seq_word,
  input logic        pad_now
);
  // R2: a frame always opens with the start code
  p_start_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_data == 16'h0000 && sof));

  // R4: the length word is one of the three legal lengths
  p_len_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    len_word |-> (out_data == 16'(LEN0_BYTES) || out_data == 16'(LEN1_BYTES) ||
                  out_data == 16'(LEN2_BYTES)));

  // R4: the packer is idle after the final word is taken
  p_idle_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> !out_valid);

  // R5: the frame number is never zero
  p_seq_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_word |-> out_data != 16'h0000);

  // R6: input is taken only while a framed word is offered
  p_take_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (out_valid && !sof));

  // R8: nothing is taken once padding has begun
  p_flush_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pad_now |-> !in_ready);

  // R10: a stalled word stays offered, nothing enters
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  p_stall_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);

  p_hdr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && (sof || len_word || seq_word)) |=> $stable(out_data));
endmodule

bind evt_framer evt_framer_chk #(
  .LEN0_BYTES(LEN0_BYTES),
  .LEN1_BYTES(LEN1_BYTES),
  .LEN2_BYTES(LEN2_BYTES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_last (out_last),
  .out_ready(out_ready),
  .sof      (sof),
  .len_word (len_word),
  .seq_word (seq_word),
  .pad_now  (pad_now)
);

// File: tb/evt_framer_tb.sv
module evt_framer_tb;
  localparam int SEQ_W = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        in_ready;
  logic [7:0]  bd_addr;
  logic [1:0]  bd_kind;
  logic        bd_master;
  logic [4:0]  bd_rev;
  logic [1:0]  rate_band;
  logic        flush;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_last;
  logic        out_ready;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  evt_framer #(.SEQ_W(SEQ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .bd_addr(bd_addr), .bd_kind(bd_kind), .bd_master(bd_master), .bd_rev(bd_rev),
    .rate_band(rate_band), .flush(flush), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready)
  );

  // bench state
  logic [15:0] fw [0:127];
  logic [15:0] accq [$];
  int          widx = 0;
  int          frames = 0;
  int          last_words, last_fill, last_data;
  int          fill_cnt, data_cnt;
  int          exp_seq = 1;
  logic [1:0]  band_s;
  logic [15:0] ident_s;
  logic [15:0] src_word;
  bit          acc_flag;
  bit          outv_seen;
  bit          prev_stall;
  logic [15:0] prev_data;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_bytes(input logic [1:0] b);
    case (b)
      2'd0:    return 64;
      2'd1:    return 128;
      default: return 256;
    endcase
  endfunction

  function automatic logic [15:0] exp_ident();
    return (16'(bd_addr) << 8) | (16'(bd_kind) << 6) | (16'(bd_master) << 5) | 16'(bd_rev);
  endfunction

  function automatic logic [15:0] new_word();
    return (16'($urandom) & 16'h7FFE) | 16'h0001;
  endfunction

  task automatic frame_check();
    chk(fw[0] == 16'h0000, "R2 start code", 32'(fw[0]), 32'h0);
    chk(fw[1] == ident_s, "R3 identity", 32'(fw[1]), 32'(ident_s));
    chk(fw[2] == 16'(exp_bytes(band_s)), "R4 length field", 32'(fw[2]), 32'(exp_bytes(band_s)));
    chk(widx == exp_bytes(band_s) / 2, "R4 word count", 32'(widx), 32'(exp_bytes(band_s) / 2));
    chk(fw[3] == 16'(exp_seq), "R5 frame number", 32'(fw[3]), 32'(exp_seq));
    exp_seq = (exp_seq == (1 << SEQ_W) - 1) ? 1 : exp_seq + 1;
    last_words = widx;
    last_fill  = fill_cnt;
    last_data  = data_cnt;
    frames++;
  endtask

  // drive has been done; sample mid-cycle, then move to the next falling edge
  task automatic step();
    #1;
    cyc++;
    acc_flag = 1'b0;
    if (out_valid) outv_seen = 1'b1;
    if (prev_stall && widx < 4 && out_valid)
      chk(out_data == prev_data, "R10 header hold", 32'(out_data), 32'(prev_data));
    if (!out_ready && in_ready) chk(1'b0, "R10 take while stalled", 32'(in_ready), 32'h0);
    if (in_valid && in_ready) begin
      accq.push_back(in_data);
      acc_flag = 1'b1;
      src_word = new_word();
    end
    if (out_valid && out_ready) begin
      if (widx == 0) begin
        band_s   = rate_band;
        ident_s  = exp_ident();
        fill_cnt = 0;
        data_cnt = 0;
      end
      if (widx < 128) fw[widx] = out_data;
      if (widx >= 4) begin
        if (out_data == 16'hFFFF) fill_cnt++;
        else begin
          data_cnt++;
          if (accq.size() == 0) chk(1'b0, "R6 unexpected data", 32'(out_data), 32'h0);
          else begin
            logic [15:0] e;
            e = accq.pop_front();
            if (out_data != e) chk(1'b0, "R6 payload order", 32'(out_data), 32'(e));
          end
        end
      end
      widx++;
      if (out_last) begin
        frame_check();
        widx = 0;
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    @(negedge clk);
    in_data = src_word;
  endtask

  task automatic wait_frame();
    int f0;
    f0 = frames;
    while (frames == f0) step();
  endtask

  task automatic drain();
    in_valid  = 1'b0;
    out_ready = 1'b1;
    step();
    while (out_valid || widx != 0) step();
  endtask

  initial begin
    #(4 * 190000);
    chk(1'b0, "watchdog", 32'(cyc), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; in_valid = 1'b0; flush = 1'b0; out_ready = 1'b1;
    bd_addr = 8'h5A; bd_kind = 2'd1; bd_master = 1'b1; bd_rev = 5'd9; rate_band = 2'd0;
    src_word = new_word(); in_data = src_word;
    prev_stall = 1'b0; prev_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid, "R1 reset out_valid", 32'(out_valid), 32'h0);
    chk(!in_ready, "R1 reset in_ready", 32'(in_ready), 32'h0);
    @(negedge clk);

    // R2: no frame without data
    outv_seen = 1'b0;
    repeat (6) step();
    chk(!outv_seen, "R2 idle without data", 32'(outv_seen), 32'h0);

    // R6: continuous frame, first frame number checked against 1 (R1)
    in_valid = 1'b1;
    wait_frame();
    in_valid = 1'b0;
    chk(last_fill == 0 && last_data == 28, "R6 full payload", 32'(last_data), 32'd28);

    // R7: one word then a pause pads the rest
    in_valid = 1'b1;
    do step(); while (!acc_flag);
    in_valid = 1'b0;
    wait_frame();
    chk(last_data == 1, "R7 data words", 32'(last_data), 32'd1);
    chk(last_fill == 27, "R7 fill words", 32'(last_fill), 32'd27);

    // R8: flush just before the sixth payload word
    in_valid = 1'b1;
    while (widx != 9) step();
    flush = 1'b1;
    step();
    flush = 1'b0;
    wait_frame();
    in_valid = 1'b0;
    chk(last_data == 5, "R8 data before flush", 32'(last_data), 32'd5);
    chk(last_fill == 23, "R8 fill after flush", 32'(last_fill), 32'd23);

    // R8: flush with no frame open does nothing
    outv_seen = 1'b0;
    flush = 1'b1;
    repeat (3) step();
    flush = 1'b0;
    repeat (4) step();
    chk(!outv_seen, "R8 idle flush", 32'(outv_seen), 32'h0);
    in_valid = 1'b1;
    wait_frame();
    in_valid = 1'b0;
    chk(last_fill == 0, "R8 no stale padding", 32'(last_fill), 32'h0);

    // R9: band change inside a frame
    rate_band = 2'd0;
    in_valid = 1'b1;
    while (widx != 6) step();
    rate_band = 2'd2;
    wait_frame();
    chk(last_words == 32, "R9 current frame", 32'(last_words), 32'd32);
    wait_frame();
    in_valid = 1'b0;
    chk(last_words == 128, "R9 next frame", 32'(last_words), 32'd128);
    drain();

    // random phases over all bands; passes the frame-number wrap (R5)
    for (int b = 0; b < 4; b++) begin
      rate_band = 2'(b);
      bd_addr = 8'($urandom); bd_kind = 2'($urandom); bd_master = 1'($urandom);
      bd_rev = 5'($urandom);
      for (int i = 0; i < 1600; i++) begin
        in_valid  = ($urandom % 10) < 7;
        out_ready = ($urandom % 10) < 8;
        step();
      end
      drain();
    end
    chk(frames > (1 << SEQ_W), "R5 wrap reached", 32'(frames), 32'(1 << SEQ_W));
    chk(accq.size() == 0, "R6 nothing lost", 32'(accq.size()), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule